// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block compares the address phase an I2C slave receives against three programmable own-address slots and three fixed reserved addresses. A byte receiver upstream delivers each completed byte with a one-cycle strobe and reports every START and repeated START. The matcher then raises one sticky flag per source. Its overall match output tells the acknowledge logic whether the slave should answer.

Each slot has its own enable and its own format select. A 7-bit slot compares the upper seven bits of its low address byte with the upper seven bits of the first received byte, and the R/W bit is not compared. A 10-bit slot takes its address from two upper bits and eight lower bits. It needs the first byte to be `11110`, then the two upper bits, then R/W = 0, and the second byte to equal the lower eight bits. The reserved detectors are general call (first byte exactly 0x00), device ID (address 1111100) and host (address 0001000). Each has its own enable.

A new START clears every flag. A repeated START keeps the flags of 10-bit slots, so that a read can resume after a 10-bit write phase. Only the first two bytes after a START or a repeated START are examined.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset all detection flags and `match_o` are 0.
- R2: A 7-bit slot (format bit 0) that is enabled sets its flag in the cycle after the first address byte is strobed, when `byte_i[7:1]` equals `slot_lo_i[7:1]` of that slot. Bit 0 of both is ignored.
- R3: A slot or reserved detector whose enable is 0 at the time its byte is strobed does not set its flag.
- R4: For an enabled 10-bit slot (format bit 1), a first byte of `{5'b11110, hi[1:0], 1'b0}` followed by a second byte equal to `lo[7:0]` sets the flag one cycle after the second byte. The first byte alone sets nothing, and a wrong second byte sets nothing.
- R5: The general call flag sets only when the first byte is exactly 8'h00 and its enable is 1. A first byte of 8'h01 does not set it.
- R6: The device-ID flag sets for first-byte bits [7:1] = 7'b1111100, and the host flag sets for bits [7:1] = 7'b0001000. For both, either R/W value is accepted.
- R7: When several slots match the same byte, every matching slot flag is set. `match_o` is 1 exactly when any flag is 1.
- R8: `start_i` clears all flags in the next cycle. A byte strobed in the same cycle as `start_i` is ignored.
- R9: `rstart_i` clears the reserved flags and the 7-bit slot flags but keeps 10-bit slot flags. After a repeated START, a kept 10-bit flag stays set only if the first byte is `{5'b11110, hi[1:0], 1'b1}`. Otherwise it is cleared.
- R10: Bytes after the second byte following a START or a repeated START leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | A new START was seen (one cycle) |
| rstart_i | input | 1 | A repeated START was seen (one cycle) |
| byte_vld_i | input | 1 | `byte_i` holds a received byte (one cycle) |
| byte_i | input | 8 | Received byte, MSB first on the wire |
| slot_en_i | input | 3 | Per-slot enable |
| slot_ten_i | input | 3 | Per-slot format: 0 = 7-bit, 1 = 10-bit |
| slot_lo_i | input | 24 | Per-slot low address byte, slot n at [8n+7:8n] |
| slot_hi_i | input | 6 | Per-slot address bits 9..8, slot n at [2n+1:2n] |
| gc_en_i | input | 1 | General call detection enable |
| devid_en_i | input | 1 | Device-ID detection enable |
| host_en_i | input | 1 | Host address detection enable |
| slot_hit_o | output | 3 | Per-slot detection flags |
| gc_hit_o | output | 1 | General call detected |
| devid_hit_o | output | 1 | Device-ID address detected |
| host_hit_o | output | 1 | Host address detected |
| match_o | output | 1 | Any detection flag set |

## Verification
The bench runs 7-bit reads and writes against two slots that differ only in bit 0. This shows that the R/W position is ignored and that several slots can match at once. The 10-bit transfers use a correct pair, a wrong second byte, and a resumed read after a repeated START. These separate the two-byte match from a first-byte-only match, and they show which flags a repeated START keeps. The reserved addresses are sent with their detectors enabled and then disabled, and with a set R/W bit. Trailing data bytes that look like addresses, and a byte strobed together with START, show that only the address phase is decoded.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int NSLOT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               rstart_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic [NSLOT-1:0]   slot_en_i,
  input  logic [NSLOT-1:0]   slot_ten_i,
  input  logic [8*NSLOT-1:0] slot_lo_i,
  input  logic [2*NSLOT-1:0] slot_hi_i,
  input  logic               gc_en_i,
  input  logic               devid_en_i,
  input  logic               host_en_i,
  output logic [NSLOT-1:0]   slot_hit_o,
  output logic               gc_hit_o,
  output logic               devid_hit_o,
  output logic               host_hit_o,
  output logic               match_o
);
  localparam logic [6:0] DEVID_ADDR = 7'b1111100;
  localparam logic [6:0] HOST_ADDR  = 7'b0001000;
  localparam logic [4:0] TEN_PFX    = 5'b11110;

  logic [1:0]       cnt;
  logic [NSLOT-1:0] pend;
  logic [NSLOT-1:0] hit_first, pend_first, hit_second;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wire [7:0] lo = slot_lo_i[8*g +: 8];
    wire [1:0] hi = slot_hi_i[2*g +: 2];
    wire first_w  = byte_i == {TEN_PFX, hi, 1'b0};
    wire first_r  = byte_i == {TEN_PFX, hi, 1'b1};
    assign hit_first[g]  = slot_en_i[g] &
                           (slot_ten_i[g] ? (slot_hit_o[g] & first_r)
                                          : (byte_i[7:1] == lo[7:1]));
    assign pend_first[g] = slot_en_i[g] & slot_ten_i[g] & first_w;
    assign hit_second[g] = pend[g] & (byte_i == lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      pend        <= '0;
      slot_hit_o  <= '0;
      gc_hit_o    <= 1'b0;
      devid_hit_o <= 1'b0;
      host_hit_o  <= 1'b0;
    end else if (start_i) begin
      cnt         <= '0;
      pend        <= '0;
      slot_hit_o  <= '0;
      gc_hit_o    <= 1'b0;
      devid_hit_o <= 1'b0;
      host_hit_o  <= 1'b0;
    end else if (rstart_i) begin
      cnt         <= '0;
      pend        <= '0;
      slot_hit_o  <= slot_hit_o & slot_ten_i;
      gc_hit_o    <= 1'b0;
      devid_hit_o <= 1'b0;
      host_hit_o  <= 1'b0;
    end else if (byte_vld_i) begin
      if (cnt == 2'd0) begin
        slot_hit_o  <= hit_first;
        pend        <= pend_first;
        gc_hit_o    <= gc_en_i & (byte_i == 8'h00);
        devid_hit_o <= devid_en_i & (byte_i[7:1] == DEVID_ADDR);
        host_hit_o  <= host_en_i & (byte_i[7:1] == HOST_ADDR);
      end else if (cnt == 2'd1) begin
        slot_hit_o  <= slot_hit_o | hit_second;
        pend        <= '0;
      end
      if (cnt != 2'd2) cnt <= cnt + 2'd1;
    end
  end

  assign match_o = (|slot_hit_o) | gc_hit_o | devid_hit_o | host_hit_o;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
  parameter int NSLOT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               rstart_i,
  input logic               byte_vld_i,
  input logic [7:0]         byte_i,
  input logic [NSLOT-1:0]   slot_en_i,
  input logic [NSLOT-1:0]   slot_ten_i,
  input logic               gc_en_i,
  input logic               devid_en_i,
  input logic               host_en_i,
  input logic [NSLOT-1:0]   slot_hit_o,
  input logic               gc_hit_o,
  input logic               devid_hit_o,
  input logic               host_hit_o,
  input logic               match_o
);
  p_rise_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_hit_o & ~$past(slot_hit_o)) != '0) |-> $past(byte_vld_i));

  p_disabled_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit_o & ~$past(slot_hit_o) & ~$past(slot_en_i)) == '0);

  p_gc_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_hit_o) |-> $past(gc_en_i && byte_i == 8'h00));

  p_devid_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devid_hit_o) |-> $past(devid_en_i && byte_i[7:1] == 7'b1111100));

  p_host_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_hit_o) |-> $past(host_en_i && byte_i[7:1] == 7'b0001000));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (slot_hit_o == '0 && !gc_hit_o && !devid_hit_o && !host_hit_o && !match_o));

  p_restart_keeps_ten_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rstart_i && !start_i) |=>
      ((slot_hit_o & ~$past(slot_hit_o & slot_ten_i)) == '0 &&
       !gc_hit_o && !devid_hit_o && !host_hit_o));
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i),
  .byte_vld_i(byte_vld_i), .byte_i(byte_i), .slot_en_i(slot_en_i),
  .slot_ten_i(slot_ten_i), .gc_en_i(gc_en_i), .devid_en_i(devid_en_i),
  .host_en_i(host_en_i), .slot_hit_o(slot_hit_o), .gc_hit_o(gc_hit_o),
  .devid_hit_o(devid_hit_o), .host_hit_o(host_hit_o), .match_o(match_o)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        start_i = 0, rstart_i = 0, byte_vld_i = 0;
  logic [7:0]  byte_i = 0;
  logic [2:0]  slot_en_i = 0, slot_ten_i = 0;
  logic [23:0] slot_lo_i = 0;
  logic [5:0]  slot_hi_i = 0;
  logic        gc_en_i = 0, devid_en_i = 0, host_en_i = 0;
  logic [2:0]  slot_hit_o;
  logic        gc_hit_o, devid_hit_o, host_hit_o, match_o;

  int checks = 0, fails = 0;

  // reference model state
  int       m_cnt = 0;
  bit [2:0] m_slot = 0, m_pend = 0;
  bit       m_gc = 0, m_dev = 0, m_host = 0;

  i2c_addr_match uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_slot = 0; m_pend = 0; m_gc = 0; m_dev = 0; m_host = 0;
    end else if (start_i) begin
      m_cnt = 0; m_slot = 0; m_pend = 0; m_gc = 0; m_dev = 0; m_host = 0;
    end else if (rstart_i) begin
      m_cnt = 0; m_pend = 0; m_gc = 0; m_dev = 0; m_host = 0;
      for (int i = 0; i < 3; i++) if (!slot_ten_i[i]) m_slot[i] = 0;
    end else if (byte_vld_i) begin
      if (m_cnt == 0) begin
        for (int i = 0; i < 3; i++) begin
          logic [7:0] lo;
          logic [1:0] hi;
          lo = slot_lo_i[8*i +: 8];
          hi = slot_hi_i[2*i +: 2];
          m_pend[i] = slot_en_i[i] && slot_ten_i[i] && byte_i == {5'b11110, hi, 1'b0};
          if (!slot_en_i[i]) m_slot[i] = 0;
          else if (slot_ten_i[i]) m_slot[i] = m_slot[i] && byte_i == {5'b11110, hi, 1'b1};
          else m_slot[i] = byte_i[7:1] == lo[7:1];
        end
        m_gc   = gc_en_i && byte_i == 8'h00;
        m_dev  = devid_en_i && byte_i[7:1] == 7'h7C;
        m_host = host_en_i && byte_i[7:1] == 7'h08;
      end else if (m_cnt == 1) begin
        for (int i = 0; i < 3; i++)
          if (m_pend[i] && byte_i == slot_lo_i[8*i +: 8]) m_slot[i] = 1;
        m_pend = 0;
      end
      if (m_cnt < 2) m_cnt++;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (slot_hit_o !== m_slot) begin
      fails++; $display("FAIL R2 slot flags: got %b expected %b", slot_hit_o, m_slot);
    end
    if (gc_hit_o !== m_gc) begin
      fails++; $display("FAIL R5 gc flag: got %b expected %b", gc_hit_o, m_gc);
    end
    if (devid_hit_o !== m_dev || host_hit_o !== m_host) begin
      fails++; $display("FAIL R6 devid/host: got %b%b expected %b%b",
                        devid_hit_o, host_hit_o, m_dev, m_host);
    end
    if (match_o !== (|m_slot || m_gc || m_dev || m_host)) begin
      fails++; $display("FAIL R7 match: got %b expected %b", match_o,
                        (|m_slot || m_gc || m_dev || m_host));
    end
  end

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] flags();
    return {slot_hit_o, gc_hit_o, devid_hit_o, host_hit_o};
  endfunction

  task automatic pulse_start();
    @(negedge clk); #1 start_i = 1;
    @(negedge clk); #1 start_i = 0;
  endtask

  task automatic pulse_rstart();
    @(negedge clk); #1 rstart_i = 1;
    @(negedge clk); #1 rstart_i = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); #1 byte_vld_i = 1; byte_i = b;
    @(negedge clk); #1 byte_vld_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    slot_en_i  = 3'b111;
    slot_ten_i = 3'b010;
    slot_lo_i  = {8'hA5, 8'hB5, 8'hA4};
    slot_hi_i  = {2'b00, 2'b10, 2'b00};
    repeat (3) @(negedge clk);
    chk("R1 reset", {flags(), 1'b0} >> 1, 6'b0);
    chk("R1 reset match", {5'b0, match_o}, 6'b0);
    #1 rst_n = 1;

    // R2 + R7: two 7-bit slots share address 0x52, R/W ignored
    pulse_start(); send(8'hA5);
    chk("R2/R7 multi", flags(), 6'b101_000);
    pulse_start(); send(8'hA4);
    chk("R2 write", flags(), 6'b101_000);
    // R10: further bytes ignored
    send(8'h00); send(8'hF9);
    chk("R10 data", flags(), 6'b101_000);

    // R3 / R5
    pulse_start(); send(8'h00);
    chk("R3 gc disabled", flags(), 6'b000_000);
    gc_en_i = 1;
    pulse_start(); send(8'h00);
    chk("R5 gc", flags(), 6'b000_100);
    chk("R7 match gc", {5'b0, match_o}, 6'b1);
    pulse_start(); send(8'h01);
    chk("R5 gc read", flags(), 6'b000_000);

    // R6
    devid_en_i = 1; host_en_i = 1;
    pulse_start(); send(8'hF9);
    chk("R6 devid", flags(), 6'b000_010);
    pulse_start(); send(8'h11);
    chk("R6 host", flags(), 6'b000_001);
    host_en_i = 0;
    pulse_start(); send(8'h10);
    chk("R3 host disabled", flags(), 6'b000_000);

    // R4: 10-bit slot1, addr 0x2B5
    pulse_start(); send(8'hF4);
    chk("R4 first only", flags(), 6'b000_000);
    send(8'hB5);
    chk("R4 ten", flags(), 6'b010_000);
    send(8'hA4);
    chk("R10 ten data", flags(), 6'b010_000);
    // R9: resume read
    pulse_rstart();
    chk("R9 kept", flags(), 6'b010_000);
    send(8'hF5);
    chk("R9 resume", flags(), 6'b010_000);
    pulse_rstart(); send(8'hA4);
    chk("R9 drop", flags(), 6'b101_000);
    pulse_rstart();
    chk("R9 clear seven", flags(), 6'b000_000);
    pulse_start(); send(8'hF4); send(8'hB4);
    chk("R4 bad second", flags(), 6'b000_000);
    pulse_start(); send(8'hF5);
    chk("R4 read without write", flags(), 6'b000_000);

    // R8: start with simultaneous byte
    pulse_start(); send(8'hA4);
    @(negedge clk); #1 start_i = 1; byte_vld_i = 1; byte_i = 8'h00;
    @(negedge clk); #1 start_i = 0; byte_vld_i = 0;
    chk("R8 start priority", flags(), 6'b000_000);

    // R3 slot disabled
    slot_en_i = 3'b110;
    pulse_start(); send(8'hA4);
    chk("R3 slot disabled", flags(), 6'b100_000);

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule